// File: doc/BRIEF.md
# Cascaded Prescaled Interval Timer Pair

This block holds three 16-bit down-counters programmed through a byte-wide write port. A one-cycle master tick input (nominally 1 MHz) advances only the prescaler counter (counter 2). Each terminal pulse of the prescaler is the count enable for the two interval counters (counters 0 and 1). So the period of an interval counter, in master ticks, is its own count times the prescaler count.

Each interval counter sets its own sticky interrupt flag on terminal count, and each flag drives a separate request line. Software drops flags by writing a bitmask to a clear address. A control word picks one counter and its operating mode. Rate-generator mode runs the counter periodically. Software-strobe mode holds the counter still, which is how software quiesces the timers. A count is loaded as two byte writes, low byte first.

Top module: `cascade_timer`

## Requirements
- R1: After reset both request lines are low and no counter runs until it is programmed.
- R2: A write to address 3 is a control word: bits [7:6] select the counter (0, 1 or 2), bits [5:4] are the access code, and bits [3:1] are the mode (3'b010 rate generator, 3'b100 software strobe). A word with select 3 or an access code other than 2'b11 is ignored and leaves every counter unchanged.
- R3: Writes to address 0, 1 or 2 load counter 0, 1 or 2 as two bytes, low byte first. A counter starts only once its high byte is written. A control word for a counter stops it and returns its byte order to the low byte.
- R4: In rate-generator mode a counter loaded with N emits a one-cycle terminal pulse on every N-th enabled cycle and reloads N. Counter 2 is enabled by the master tick. Counters 0 and 1 are enabled by counter 2's pulse, so flag k first rises exactly Nk*N2 master ticks after counting starts.
- R5: A loaded count of 0 or 1 is treated as 2.
- R6: The terminal pulse of counter 0 sets irq0 and that of counter 1 sets irq1. Each flag stays set until cleared.
- R7: A write to address 4 clears flag 0 when data bit 0 is 1 and flag 1 when data bit 1 is 1. The value 0x03 clears both.
- R8: If a terminal pulse and a clear of the same flag fall in one cycle, the flag ends set.
- R9: A counter whose last control word chose software-strobe mode (or any mode other than rate generator) produces no terminal pulses, even after both count bytes are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Master tick, one-cycle enable for counter 2 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0..2 counter data, 3 control, 4 flag clear |
| wr_data | input | 8 | Write data byte |
| irq0 | output | 1 | Interrupt request from counter 0 flag |
| irq1 | output | 1 | Interrupt request from counter 1 flag |

## Verification
On every cycle the assertions check the flag rules: stickiness, bitmask clearing and a set beating a clear. They also check that a control word stops its counter, that a running counter never holds zero, and that a terminal pulse reloads the programmed value. Only the bench scenarios can show the end-to-end timing: the product of the two counts in master ticks, byte order with pointer reset, clamping of small counts, and that ignored control words and strobe mode leave the request lines as they must be.

// File: rtl/cascade_timer_pkg.sv
package cascade_timer_pkg;
    localparam int CNT_W    = 16;
    localparam int BYTE_W   = 8;
    localparam int NUM_CNT  = 3;
    localparam int NUM_IRQ  = 2;
    localparam int ADDR_W   = 3;
    localparam int PRE_IDX  = 2;
    localparam int MIN_CNT  = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_CLR  = 3'd4;

    localparam logic [1:0] ACC_WORD    = 2'b11;
    localparam logic [2:0] MODE_RATE   = 3'b010;
    localparam logic [2:0] MODE_STROBE = 3'b100;

    typedef struct packed {
        logic [1:0] sel;
        logic [1:0] acc;
        logic [2:0] mode;
        logic       rsvd;
    } ctrl_word_t;

    typedef struct packed {
        logic [CNT_W-1:0]  count;
        logic [CNT_W-1:0]  reload;
        logic [BYTE_W-1:0] lo_byte;
        logic              hi_next;
        logic              rate;
        logic              running;
    } cnt_state_t;

    function automatic logic [CNT_W-1:0] clamp_count(input logic [CNT_W-1:0] v);
        return (v < CNT_W'(MIN_CNT)) ? CNT_W'(MIN_CNT) : v;
    endfunction
endpackage

// File: rtl/cascade_timer_dec.sv
module cascade_timer_dec
    import cascade_timer_pkg::*;
(
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [BYTE_W-1:0]   wr_data,
    output logic [NUM_CNT-1:0]  cfg_wr,
    output logic                cfg_rate,
    output logic [NUM_CNT-1:0]  data_wr,
    output logic                clr_wr
);
    ctrl_word_t cw;
    logic       ctrl_ok;

    assign cw       = ctrl_word_t'(wr_data);
    assign ctrl_ok  = wr_en && (wr_addr == ADDR_CTRL) && (cw.acc == ACC_WORD);
    assign cfg_rate = (cw.mode == MODE_RATE);
    assign clr_wr   = wr_en && (wr_addr == ADDR_CLR);

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_sel
        assign cfg_wr[i]  = ctrl_ok && (cw.sel == 2'(i));
        assign data_wr[i] = wr_en && (wr_addr == ADDR_W'(i));
    end
endmodule

// File: rtl/cascade_timer_counter.sv
module cascade_timer_counter
    import cascade_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              cfg_rate,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] data,
    input  logic              en,
    output logic              tc
);
    cnt_state_t       st;
    logic [CNT_W-1:0] new_val;
    logic             load_hi;

    assign new_val = clamp_count({data, st.lo_byte});
    assign load_hi = data_wr && !cfg_wr && st.hi_next;
    assign tc      = st.running && en && (st.count == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (cfg_wr) begin
            st.rate    <= cfg_rate;
            st.hi_next <= 1'b0;
            st.running <= 1'b0;
        end else begin
            if (data_wr && !st.hi_next) begin
                st.lo_byte <= data;
                st.hi_next <= 1'b1;
            end
            if (load_hi) begin
                st.hi_next <= 1'b0;
                st.reload  <= new_val;
                st.count   <= new_val;
                st.running <= st.rate;
            end else if (st.running && en) begin
                st.count <= tc ? st.reload : st.count - CNT_W'(1);
            end
        end
    end

    p_run_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
        st.running |-> (st.count != '0));
    p_ctrl_stops_r3: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> !st.running);
    p_reload_r4: assert property (@(posedge clk) disable iff (rst)
        (tc && !cfg_wr && !data_wr) |=> (st.count == $past(st.reload)));
    p_strobe_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && !cfg_rate) |=> !tc);
endmodule

// File: rtl/cascade_timer_flags.sv
module cascade_timer_flags
    import cascade_timer_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] set_in,
    input  logic               clr_wr,
    input  logic [NUM_IRQ-1:0] clr_mask,
    output logic [NUM_IRQ-1:0] flag
);
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_flag
        logic clr_i;
        assign clr_i = clr_wr && clr_mask[i];

        always_ff @(posedge clk) begin
            if (rst)            flag[i] <= 1'b0;
            else if (set_in[i]) flag[i] <= 1'b1;
            else if (clr_i)     flag[i] <= 1'b0;
        end

        p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
            set_in[i] |=> flag[i]);
        p_clear_r7: assert property (@(posedge clk) disable iff (rst)
            (clr_i && !set_in[i]) |=> !flag[i]);
        p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
            (flag[i] && !clr_i) |=> flag[i]);
    end
endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
    import cascade_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [7:0]        wr_data,
    output logic              irq0,
    output logic              irq1
);
    logic [NUM_CNT-1:0] cfg_wr;
    logic [NUM_CNT-1:0] data_wr;
    logic [NUM_CNT-1:0] cnt_en;
    logic [NUM_CNT-1:0] cnt_tc;
    logic [NUM_IRQ-1:0] flags;
    logic               cfg_rate;
    logic               clr_wr;

    cascade_timer_dec u_dec (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cfg_wr   (cfg_wr),
        .cfg_rate (cfg_rate),
        .data_wr  (data_wr),
        .clr_wr   (clr_wr)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        if (i == PRE_IDX) begin : g_pre
            assign cnt_en[i] = tick;
        end else begin : g_int
            assign cnt_en[i] = cnt_tc[PRE_IDX];
        end

        cascade_timer_counter u_cnt (
            .clk      (clk),
            .rst      (rst),
            .cfg_wr   (cfg_wr[i]),
            .cfg_rate (cfg_rate),
            .data_wr  (data_wr[i]),
            .data     (wr_data),
            .en       (cnt_en[i]),
            .tc       (cnt_tc[i])
        );
    end

    cascade_timer_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .set_in   (cnt_tc[NUM_IRQ-1:0]),
        .clr_wr   (clr_wr),
        .clr_mask (wr_data[NUM_IRQ-1:0]),
        .flag     (flags)
    );

    assign irq0 = flags[0];
    assign irq1 = flags[1];

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq0 && !irq1));
endmodule

// File: tb/cascade_timer_tb.sv
module cascade_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       irq0, irq1;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int t0, t1;

    always #2 clk = ~clk;

    cascade_timer dut_i (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .irq0(irq0), .irq1(irq1)
    );

    function automatic int eff(input int v);
        return (v < 2) ? 2 : v;
    endfunction

    function automatic logic [7:0] ctrl(input int sel, input logic [1:0] acc,
                                        input logic [2:0] mode);
        return {2'(sel), acc, mode, 1'b0};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic prog(input int sel, input logic [2:0] mode, input int val);
        wr(3'd3, ctrl(sel, 2'b11, mode));
        wr(3'(sel), 8'(val));
        wr(3'(sel), 8'(val >> 8));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; tick = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Runs ticks; records first tick edge at which each irq is seen high.
    // A clear with mask clr_mask is presented at tick edge clr_at (0 = none).
    task automatic run(input int limit, input int clr_at, input logic [7:0] clr_mask);
        t0 = 0; t1 = 0;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            tick = 1'b1;
            if (i == clr_at) begin
                wr_en = 1'b1; wr_addr = 3'd4; wr_data = clr_mask;
            end else begin
                wr_en = 1'b0;
            end
            @(posedge clk);
            #1;
            if (irq0 && t0 == 0) t0 = i;
            if (irq1 && t1 == 0) t1 = i;
        end
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd7331));
        do_reset();
        #1;
        check("R1 irq0 after reset", irq0, 0);
        check("R1 irq1 after reset", irq1, 0);
        run(40, 0, 8'h00);
        check("R1 unprogrammed irq0", t0, 0);
        check("R1 unprogrammed irq1", t1, 0);

        // R4 / R6: random counts, cascade product timing
        for (int r = 0; r < 4; r++) begin
            int p, n0, n1;
            p  = 2 + int'($urandom_range(4));
            n0 = 2 + int'($urandom_range(6));
            n1 = 2 + int'($urandom_range(6));
            do_reset();
            prog(2, 3'b010, p);
            prog(0, 3'b010, n0);
            prog(1, 3'b010, n1);
            run(n0 * p + n1 * p + 4, 0, 8'h00);
            check("R4 irq0 first rise", t0, n0 * p);
            check("R4 irq1 first rise", t1, n1 * p);
            #1;
            check("R6 irq0 sticky", irq0, 1);
            check("R6 irq1 sticky", irq1, 1);
        end

        // R7: selective clear, flags frozen with tick low
        wr(3'd4, 8'h02);
        #1;
        check("R7 bit1 clears irq1", irq1, 0);
        check("R7 bit1 keeps irq0", irq0, 1);
        wr(3'd4, 8'h03);
        #1;
        check("R7 0x03 clears irq0", irq0, 0);
        check("R7 0x03 clears irq1", irq1, 0);

        // R5: counts of 0 and 1 act as 2
        do_reset();
        prog(2, 3'b010, 0);
        prog(0, 3'b010, 1);
        run(10, 0, 8'h00);
        check("R5 clamp to 2", t0, 4);

        // R3: control word resets byte order; low byte alone does not start
        do_reset();
        prog(2, 3'b010, 3);
        wr(3'd3, ctrl(0, 2'b11, 3'b010));
        wr(3'd0, 8'h55);
        wr(3'd3, ctrl(0, 2'b11, 3'b010));
        wr(3'd0, 8'd5);
        wr(3'd0, 8'd0);
        wr(3'd3, ctrl(1, 2'b11, 3'b010));
        wr(3'd1, 8'd2);
        run(60, 0, 8'h00);
        check("R3 pointer reset period", t0, 15);
        check("R3 low byte only stays idle", t1, 0);

        // R9: strobe mode quiesces; R2: ignored control words
        do_reset();
        prog(2, 3'b010, 2);
        prog(0, 3'b100, 3);
        prog(1, 3'b010, 4);
        wr(3'd3, ctrl(1, 2'b01, 3'b100));
        wr(3'd3, ctrl(3, 2'b11, 3'b100));
        run(40, 0, 8'h00);
        check("R9 strobe mode no irq0", t0, 0);
        check("R2 ignored words keep counter 1", t1, 8);

        // R8: clear coincident with set of flag 0
        do_reset();
        prog(2, 3'b010, 2);
        prog(0, 3'b010, 3);
        run(6, 6, 8'h01);
        check("R8 set wins over clear", t0, 6);
        wr(3'd4, 8'h01);
        #1;
        check("R7 clear after set", irq0, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule